// File: doc/BRIEF.md
# Sequential Page Read Streamer

This block is the read engine on the device side of a paged flash memory. A command decoder gives it a start row and a start column with a one-cycle `start` strobe. The engine then holds the ready/busy line low while the addressed row is copied from the cell array into a one-page buffer. When the copy is complete it releases the line and returns one byte for each read strobe. Bytes come out in column order, from the start column up to the last column of the page.

When the host keeps strobing past the last column, the engine loads the next row by itself and continues from column 0. This only happens while chip-enable is held low, and only inside the current block of rows. Reaching the end of the last row of a block ends the operation. Holding chip-enable high for a set number of cycles also ends it.

A mode input, latched with `start`, selects a chip-enable-insensitive mode. In that mode chip-enable neither gates the strobes nor ends the operation, and reading stops at the end of the first page. The cell array is a computed, read-only pattern, so the engine can be used without program or erase logic.

Top module: `seq_page_reader`

## Requirements
- R1: After reset, `rb_n` is 1 and `dout_valid` is 0.
- R2: After `start` is sampled, `rb_n` is 0 for exactly LOAD_CYC cycles, beginning with the next cycle, and then returns to 1.
- R3: When `rb_n` is 1 and a read strobe is accepted, `dout_valid` is 1 for exactly the next cycle and `dout` carries the byte at the current row and column. The first accepted strobe reads the start column, and each later one reads the next column.
- R4: The byte at row r and column c is ((r*3 + c) mod 256) XOR 0xA5. Each page has 2**COL_W columns, and the last column is 2**COL_W - 1.
- R5: After the last column has been read, the next accepted strobe returns no data. It starts an automatic load of row r+1, with `rb_n` low for LOAD_CYC cycles.
- R6: A read strobe has no effect and gives no `dout_valid` in any of these cases: `rb_n` is 0, the engine is idle, or `ce_n` is 1 outside the insensitive mode.
- R7: A page loaded automatically is read starting at column 0, whatever the start column of the first page was.
- R8: A row is the last of its block when its low PAGE_W bits are all ones. After the last column of such a row is read, the operation ends: `rb_n` stays 1 and no further data is returned until a new `start`.
- R9: When `ce_dont_care` is 1 at `start`, reading ends after the last column of the first page. Strobes are accepted regardless of `ce_n`, and `ce_n` never ends the operation.
- R10: Outside the insensitive mode, `ce_n` held at 1 for CE_HOLD_CYC consecutive sampled cycles ends any operation in progress, including a load. A shorter high period changes nothing.
- R11: `start` is accepted in any state and restarts the engine with the new row and column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle strobe that begins a read |
| start_row | input | BLK_W+PAGE_W | Row address of the first page |
| start_col | input | COL_W | First column to return |
| ce_dont_care | input | 1 | Selects the chip-enable-insensitive mode; latched with start |
| ce_n | input | 1 | Chip enable, active low |
| re_pulse | input | 1 | One-cycle read strobe |
| rb_n | output | 1 | Ready (1) or busy loading a page (0) |
| dout | output | 8 | Byte returned for the last accepted strobe |
| dout_valid | output | 1 | High for one cycle when dout carries a new byte |

## Verification
The bench aims at page and block edges. It starts reads at the last column, at the last page of a block, and one page before it. A design that wraps within the page, or that carries the automatic load into the next block, would return bytes where the expected model returns none. Read strobes are scattered through every load window, and chip-enable is raised for one cycle fewer than the threshold. An engine that counted early strobes would shift every later column, and one that ended early would drop rows. The insensitive mode and restarts made mid-page catch designs that keep stale mode or column state across commands.

// File: rtl/sr_pkg.sv
// Package: shared state encoding and cell-array content function for the
// sequential page read streamer. Assumes rows fit in 16 bits.
package sr_pkg;

    localparam int CELL_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_READ = 2'd2,
        ST_NEXT = 2'd3
    } sr_state_t;

    // Content of one cell: ((row*3 + col) mod 256) xor 0xA5.
    function automatic logic [CELL_W-1:0] sr_cell(input logic [15:0] row,
                                                   input logic [15:0] col);
        logic [15:0] mix;
        mix = row * 16'd3 + col;
        return mix[CELL_W-1:0] ^ 8'hA5;
    endfunction

endpackage

// File: rtl/sr_cell_array.sv
// Module: read-only cell array. Returns the byte stored at (row, col)
// combinationally. Assumes ROW_W and COL_W are each at most 16.
module sr_cell_array #(
    parameter int ROW_W = 7,
    parameter int COL_W = 4
) (
    input  logic [ROW_W-1:0]         row_i,
    input  logic [COL_W-1:0]         col_i,
    output logic [sr_pkg::CELL_W-1:0] data_o
);
    // Computed content lookup.
    always_comb begin
        data_o = sr_pkg::sr_cell(16'(row_i), 16'(col_i));
    end
endmodule

// File: rtl/sr_page_buffer.sv
// Module: one-page data buffer with one write port and one asynchronous
// read port. Assumes write and read of the same column never need bypass.
module sr_page_buffer #(
    parameter int COL_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [COL_W-1:0]  wcol_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [COL_W-1:0]  rcol_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int COLS = 1 << COL_W;

    logic [DATA_W-1:0] mem_q [COLS];

    // Store one column per write strobe.
    always_ff @(posedge clk) begin
        if (we_i) mem_q[wcol_i] <= wdata_i;
    end

    // Present the selected column.
    assign rdata_o = mem_q[rcol_i];
endmodule

// File: rtl/sr_ctrl.sv
// Module: sequencing control. Loads a page over LOAD_CYC cycles, steps the
// column pointer on accepted strobes, chains pages inside a block, and ends
// on block end, page end in insensitive mode, or a long chip-enable high.
// Assumes LOAD_CYC >= 2**COL_W so every column is written during a load.
module sr_ctrl #(
    parameter int COL_W       = 4,
    parameter int PAGE_W      = 5,
    parameter int BLK_W       = 2,
    parameter int LOAD_CYC    = 20,
    parameter int CE_HOLD_CYC = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [BLK_W+PAGE_W-1:0] start_row_i,
    input  logic [COL_W-1:0]        start_col_i,
    input  logic                    dc_mode_i,
    input  logic                    ce_n_i,
    input  logic                    re_i,
    output logic [BLK_W+PAGE_W-1:0] row_o,
    output logic [COL_W-1:0]        rcol_o,
    output logic                    buf_we_o,
    output logic [COL_W-1:0]        buf_wcol_o,
    output logic                    emit_o,
    output logic                    rb_n_o
);
    import sr_pkg::*;

    localparam int ROW_W = BLK_W + PAGE_W;
    localparam int COLS  = 1 << COL_W;
    localparam int LCW   = $clog2(LOAD_CYC + 1);
    localparam int CCW   = $clog2(CE_HOLD_CYC + 1);
    localparam logic [LCW-1:0] LD_LAST = LCW'(LOAD_CYC - 1);
    localparam logic [LCW-1:0] LD_COLS = LCW'(COLS);
    localparam logic [CCW-1:0] CE_LAST = CCW'(CE_HOLD_CYC - 1);

    sr_state_t        state_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [LCW-1:0]   ld_cnt_q;
    logic [CCW-1:0]   ce_cnt_q;
    logic             dc_q;

    logic active, strobe_ok, ce_quit, take, next_go, last_col, last_page;

    // Decode of the current cycle's events.
    always_comb begin
        active    = (state_q != ST_IDLE);
        strobe_ok = re_i && (dc_q || !ce_n_i);
        ce_quit   = active && !dc_q && ce_n_i && (ce_cnt_q == CE_LAST);
        take      = (state_q == ST_READ) && strobe_ok;
        next_go   = (state_q == ST_NEXT) && strobe_ok;
        last_col  = (col_q == {COL_W{1'b1}});
        last_page = (row_q[PAGE_W-1:0] == {PAGE_W{1'b1}});
    end

    // Main sequencer: start has priority, then chip-enable termination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            row_q    <= '0;
            col_q    <= '0;
            ld_cnt_q <= '0;
            dc_q     <= 1'b0;
        end else if (start_i) begin
            state_q  <= ST_LOAD;
            row_q    <= start_row_i;
            col_q    <= start_col_i;
            ld_cnt_q <= '0;
            dc_q     <= dc_mode_i;
        end else if (ce_quit) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_LOAD: begin
                    if (ld_cnt_q == LD_LAST) state_q <= ST_READ;
                    else ld_cnt_q <= ld_cnt_q + 1'b1;
                end
                ST_READ: begin
                    if (take) begin
                        col_q <= col_q + 1'b1;
                        if (last_col)
                            state_q <= (dc_q || last_page) ? ST_IDLE : ST_NEXT;
                    end
                end
                ST_NEXT: begin
                    if (next_go) begin
                        row_q    <= row_q + 1'b1;
                        col_q    <= '0;
                        ld_cnt_q <= '0;
                        state_q  <= ST_LOAD;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Count consecutive chip-enable-high cycles while an operation runs.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i || !ce_n_i || !active || dc_q) ce_cnt_q <= '0;
        else ce_cnt_q <= ce_cnt_q + 1'b1;
    end

    assign row_o      = row_q;
    assign rcol_o     = col_q;
    assign buf_we_o   = (state_q == ST_LOAD) && (ld_cnt_q < LD_COLS);
    assign buf_wcol_o = ld_cnt_q[COL_W-1:0];
    assign emit_o     = take;
    assign rb_n_o     = (state_q != ST_LOAD);

    // Busy only follows a command or an automatic next-page request.
    assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rb_n_o) |-> ($past(start_i) || $past(next_go)));

    // R5: an automatic load is entered on the strobe after the last column.
    assert_next_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (next_go && !start_i && !ce_quit) |=> !rb_n_o);

    // An automatically loaded page begins at column 0.
    assert_auto_col0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (next_go && !start_i && !ce_quit) |=> (col_q == '0));

    // Automatic continuation never leaves the block.
    assert_same_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (next_go && !start_i && !ce_quit) |=>
        (row_q[ROW_W-1:PAGE_W] == $past(row_q[ROW_W-1:PAGE_W])));

    // The insensitive mode never waits for a next page.
    assert_dc_no_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NEXT) |-> !dc_q);

    // A long chip-enable high ends the operation.
    assert_ce_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_quit && !start_i) |=> (rb_n_o && state_q == ST_IDLE));
endmodule

// File: rtl/seq_page_reader.sv
// Module: top of the sequential page read streamer. Joins the control,
// the cell array and the page buffer, and registers the output byte.
// Assumes start_row and start_col are valid in the cycle start is high.
module seq_page_reader #(
    parameter int COL_W       = 4,
    parameter int PAGE_W      = 5,
    parameter int BLK_W       = 2,
    parameter int LOAD_CYC    = 20,
    parameter int CE_HOLD_CYC = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [BLK_W+PAGE_W-1:0] start_row,
    input  logic [COL_W-1:0]        start_col,
    input  logic                    ce_dont_care,
    input  logic                    ce_n,
    input  logic                    re_pulse,
    output logic                    rb_n,
    output logic [7:0]              dout,
    output logic                    dout_valid
);
    localparam int ROW_W  = BLK_W + PAGE_W;
    localparam int DATA_W = sr_pkg::CELL_W;

    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  rcol, wcol;
    logic              buf_we, emit;
    logic [DATA_W-1:0] cell_data, buf_data;

    sr_ctrl #(
        .COL_W(COL_W), .PAGE_W(PAGE_W), .BLK_W(BLK_W),
        .LOAD_CYC(LOAD_CYC), .CE_HOLD_CYC(CE_HOLD_CYC)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .start_row_i(start_row), .start_col_i(start_col),
        .dc_mode_i(ce_dont_care), .ce_n_i(ce_n), .re_i(re_pulse),
        .row_o(row), .rcol_o(rcol), .buf_we_o(buf_we), .buf_wcol_o(wcol),
        .emit_o(emit), .rb_n_o(rb_n)
    );

    sr_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W)) array_i (
        .row_i(row), .col_i(wcol), .data_o(cell_data)
    );

    sr_page_buffer #(.COL_W(COL_W), .DATA_W(DATA_W)) pbuf_i (
        .clk(clk), .we_i(buf_we), .wcol_i(wcol), .wdata_i(cell_data),
        .rcol_i(rcol), .rdata_o(buf_data)
    );

    // Output register: capture the byte for each accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            dout_valid <= emit;
            if (emit) dout <= buf_data;
        end
    end

    // A byte only follows a strobe seen while the engine was ready.
    assert_valid_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> ($past(re_pulse) && $past(rb_n)));

    // No byte appears one cycle after a busy cycle.
    assert_busy_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rb_n |=> !dout_valid);
endmodule

// File: tb/seq_page_reader_tb_top.sv
module seq_page_reader_tb_top;
    localparam int COL_W = 4, PAGE_W = 5, BLK_W = 2;
    localparam int LOAD_CYC = 20, CE_HOLD_CYC = 6;
    localparam int COLS = 1 << COL_W;
    localparam int ROW_W = BLK_W + PAGE_W;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ce_dont_care = 1'b0;
    logic ce_n = 1'b0, re_pulse = 1'b0;
    logic [ROW_W-1:0] start_row = '0;
    logic [COL_W-1:0] start_col = '0;
    logic rb_n, dout_valid;
    logic [7:0] dout;

    int checks = 0, errors = 0;
    int m_state = 0;  // 0 idle, 1 read, 2 waiting for next page
    int m_row = 0, m_col = 0;
    bit m_dc = 0;

    always #10 clk = ~clk;

    seq_page_reader #(.COL_W(COL_W), .PAGE_W(PAGE_W), .BLK_W(BLK_W),
        .LOAD_CYC(LOAD_CYC), .CE_HOLD_CYC(CE_HOLD_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_row(start_row),
        .start_col(start_col), .ce_dont_care(ce_dont_care), .ce_n(ce_n),
        .re_pulse(re_pulse), .rb_n(rb_n), .dout(dout), .dout_valid(dout_valid));

    function automatic logic [7:0] exp_cell(int row, int col);
        return 8'((row * 3 + col) & 255) ^ 8'hA5;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Count busy cycles while scattering ignored strobes (R2, R6).
    task automatic wait_load(string req);
        int cnt = 0;
        while (rb_n == 1'b0 && cnt < 1000) begin
            re_pulse = 1'($urandom % 2);
            cnt++;
            @(negedge clk);
            check(dout_valid == 1'b0, "R6", int'(dout_valid), 0);
        end
        re_pulse = 1'b0;
        check(cnt == LOAD_CYC, req, cnt, LOAD_CYC);
        m_state = 1;
    endtask

    task automatic do_start(int row, int col, bit dc, bit wl);
        start = 1'b1; start_row = ROW_W'(row); start_col = COL_W'(col);
        ce_dont_care = dc; re_pulse = 1'b0;
        @(negedge clk);
        start = 1'b0;
        m_row = row; m_col = col; m_dc = dc;
        check(rb_n == 1'b0, "R11", int'(rb_n), 0);
        if (wl) wait_load("R2");
    endtask

    task automatic pulse();
        bit eff = m_dc || !ce_n;
        re_pulse = 1'b1;
        @(negedge clk);
        re_pulse = 1'b0;
        if (m_state == 1 && eff) begin
            check(dout_valid == 1'b1, "R3", int'(dout_valid), 1);
            check(dout == exp_cell(m_row, m_col), (m_col == 0) ? "R7" : "R4",
                  int'(dout), int'(exp_cell(m_row, m_col)));
            if (m_col == COLS - 1) begin
                if (m_dc || (m_row % (1 << PAGE_W)) == (1 << PAGE_W) - 1) m_state = 0;
                else m_state = 2;
            end else m_col++;
        end else if (m_state == 2 && eff) begin
            check(dout_valid == 1'b0, "R5", int'(dout_valid), 0);
            m_row++; m_col = 0;
            wait_load("R5");
        end else begin
            check(dout_valid == 1'b0, "R6", int'(dout_valid), 0);
        end
    endtask

    task automatic ce_blip(int n);
        ce_n = 1'b1;
        pulse();
        repeat (n - 1) @(negedge clk);
        ce_n = 1'b0;
    endtask

    task automatic ce_kill();
        ce_n = 1'b1;
        repeat (CE_HOLD_CYC) @(negedge clk);
        ce_n = 1'b0;
        if (!m_dc) begin
            m_state = 0;
            check(rb_n == 1'b1, "R10", int'(rb_n), 1);
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL R2 watchdog act=hung exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(rb_n == 1'b1, "R1", int'(rb_n), 1);
        check(dout_valid == 1'b0, "R1", int'(dout_valid), 0);
        pulse();  // R6: idle strobe ignored

        // R8: last page of block 1 from column 14
        do_start(63, 14, 0, 1);
        repeat (3) pulse();
        check(rb_n == 1'b1, "R8", int'(rb_n), 1);

        // R5, R7, R8: page 30 from last column, chain into page 31
        do_start(62, 15, 0, 1);
        repeat (COLS + 3) pulse();
        check(m_state == 0 && rb_n == 1'b1, "R8", int'(rb_n), 1);

        // R9: insensitive mode stops at page end, strobes pass with ce_n high
        do_start(5, 13, 1, 1);
        ce_n = 1'b1;
        repeat (4) pulse();
        ce_n = 1'b0;
        check(rb_n == 1'b1, "R9", int'(rb_n), 1);

        // R10: short high keeps going, long high during a load ends it
        do_start(9, 2, 0, 1);
        pulse();
        ce_blip(CE_HOLD_CYC - 1);
        repeat (2) pulse();
        do_start(17, 0, 0, 0);
        ce_kill();
        pulse();

        // R11: restart in the middle of a page
        do_start(40, 3, 0, 1);
        repeat (2) pulse();
        do_start(41, 8, 0, 1);
        repeat (3) pulse();

        // Random mix
        for (int op = 0; op < 40; op++) begin
            int row = int'($urandom % (1 << ROW_W));
            if ($urandom % 2) row = (row & ~31) | (28 + int'($urandom % 4));
            do_start(row, int'($urandom % COLS), ($urandom % 4) == 0, 1);
            for (int k = 0; k < 10 + int'($urandom % 50); k++) begin
                int pick = int'($urandom % 100);
                if (pick < 85) pulse();
                else if (pick < 93) ce_blip(1 + int'($urandom % (CE_HOLD_CYC - 1)));
                else if (pick < 97) ce_kill();
                else do_start(int'($urandom % (1 << ROW_W)), int'($urandom % COLS), 0, 1);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule